// File: doc/BRIEF.md
# Status Queue Producer

The block posts device status into a circular queue that lives in host memory. A status word comes in over a valid/ready stream. For each word it accepts, the block issues one memory write. The write carries the entry with its valid flag set, and it goes to the slot the write pointer selects, offset from a host-programmed base address. The block then advances its write pointer and pulses an interrupt request, which the host can mask.

The host does not give the block a live read pointer. From time to time it writes a read-update position into a register, and the block judges fullness against that lagging copy only. When the next slot would reach the slot just before the read-update position, the block stops accepting input. It also records a sticky overflow flag that stays set until the host clears it.

Back-pressure rules on the input stream:
- `in_ready` depends only on the write pointer and the read-update register. It never depends on `in_valid`.
- A source that sees `in_ready` low must hold `in_valid` and `in_status` steady.
- Once the host moves the read-update position forward, the held word is taken on the first cycle that `in_ready` is high.

Top module: `stq_producer`

## Requirements
- R1: Every written entry is 32 bits. Bit 31 (the valid flag) is 1, and bits 30:0 carry the accepted status payload unchanged.
- R2: A word accepted at a clock edge produces exactly one write, with `mem_wr_en` high for the following cycle. The address is base + write_pointer × ENTRY_WORDS (default 2), and the write pointer then advances by one.
- R3: The write pointer counts modulo DEPTH (default 16), so the entry after slot DEPTH-1 goes to the base address.
- R4: The queue is full when write_pointer equals (read_update − 1) mod DEPTH. While full, `in_ready` is 0 and no write is issued.
- R5: `overflow` goes to 1 at the edge after any cycle with `in_valid` high while full. It stays 1 until a control write with bit 1 set clears it, and a new overflow in the same cycle wins over the clear.
- R6: Each write is accompanied by a one-cycle `irq` pulse, unless control bit 0 (the mask) was 1 when the word was accepted.
- R7: Host registers are selected by `reg_addr`: 0 is the base address, 1 is the read-update position (low log2(DEPTH) bits), and 2 is control. A register write takes effect for fullness and addressing from the next cycle.
- R8: After reset, the write pointer, the read-update position, the base and the mask are all 0. `in_ready` is 1, and `mem_wr_en`, `irq` and `overflow` are 0.
- R9: A word stalled by a full queue is written with its original payload, at the next write pointer slot, once the host advances the read-update position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Status word offered |
| in_ready | output | 1 | Block can accept a word |
| in_status | input | PAYLOAD_W (31) | Status payload |
| mem_wr_en | output | 1 | One-cycle memory write strobe |
| mem_wr_addr | output | ADDR_W (32) | Word address of the entry |
| mem_wr_data | output | 32 | Entry: valid flag and payload |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 32 | Host register write data |
| irq | output | 1 | Interrupt request pulse |
| overflow | output | 1 | Sticky overflow flag |

## Verification
Several properties are checked on every cycle:
- every write carries the valid flag;
- each acceptance yields exactly one write on the next cycle;
- an interrupt pulse never appears without a write, and never while the mask was set;
- an offer refused while full sets the overflow flag, which then holds until it is cleared.

Other behaviour can only be shown by the bench's scenarios:
- the exact address sequence, including wrap to the base;
- a base change taking effect;
- fullness following a moved read-update position;
- a stalled word arriving intact after the host releases space.

// File: rtl/stq_pkg.sv
package stq_pkg;
  localparam int unsigned ENTRY_W   = 32;
  localparam int unsigned VALID_BIT = 31;
  localparam int unsigned CTRL_MASK = 0;
  localparam int unsigned CTRL_CLR  = 1;

  typedef enum logic [1:0] {
    REG_BASE  = 2'd0,
    REG_RDUPD = 2'd1,
    REG_CTRL  = 2'd2
  } stq_reg_e;
endpackage

// File: rtl/stq_regs.sv
module stq_regs
  import stq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [ADDR_W-1:0] base,
  output logic [PTR_W-1:0]  rd_upd,
  output logic              irq_mask,
  output logic              ovf_clr
);
  logic sel_base, sel_rd, sel_ctrl;

  assign sel_base = reg_wr && (reg_addr == REG_BASE);
  assign sel_rd   = reg_wr && (reg_addr == REG_RDUPD);
  assign sel_ctrl = reg_wr && (reg_addr == REG_CTRL);
  assign ovf_clr  = sel_ctrl && reg_wdata[CTRL_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base     <= '0;
      rd_upd   <= '0;
      irq_mask <= 1'b0;
    end else begin
      if (sel_base) base     <= ADDR_W'(reg_wdata);
      if (sel_rd)   rd_upd   <= reg_wdata[PTR_W-1:0];
      if (sel_ctrl) irq_mask <= reg_wdata[CTRL_MASK];
    end
  end
endmodule

// File: rtl/stq_ptr.sv
module stq_ptr #(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [PTR_W-1:0] rd_upd,
  output logic [PTR_W-1:0] wptr,
  output logic             full
);
  logic [PTR_W-1:0] limit;

  // The minus-one wraps within PTR_W bits, matching the pointer wrap.
  assign limit = rd_upd - 1'b1;
  assign full  = (wptr == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       wptr <= '0;
    else if (advance) wptr <= wptr + 1'b1;
  end
endmodule

// File: rtl/stq_emit.sv
module stq_emit
  import stq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PAYLOAD_W   = 31,
  parameter int unsigned PTR_W       = 4,
  parameter int unsigned ENTRY_WORDS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [PAYLOAD_W-1:0] payload,
  input  logic [ADDR_W-1:0]    base,
  input  logic [PTR_W-1:0]     wptr,
  input  logic                 irq_mask,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [ENTRY_W-1:0]   wr_data,
  output logic                 irq
);
  logic [ADDR_W-1:0]  slot_addr;
  logic [ENTRY_W-1:0] entry;

  assign slot_addr = base + ADDR_W'(wptr) * ADDR_W'(ENTRY_WORDS);

  always_comb begin
    entry = '0;
    entry[PAYLOAD_W-1:0] = payload;
    entry[VALID_BIT]     = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      irq     <= 1'b0;
    end else begin
      wr_en <= fire;
      irq   <= fire && !irq_mask;
      if (fire) begin
        wr_addr <= slot_addr;
        wr_data <= entry;
      end
    end
  end
endmodule

// File: rtl/stq_producer.sv
module stq_producer
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PAYLOAD_W   = 31,
  parameter int unsigned ENTRY_WORDS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PAYLOAD_W-1:0] in_status,
  output logic                 mem_wr_en,
  output logic [ADDR_W-1:0]    mem_wr_addr,
  output logic [31:0]          mem_wr_data,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic                 irq,
  output logic                 overflow
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  rd_upd;
  logic [PTR_W-1:0]  wptr;
  logic              irq_mask;
  logic              ovf_clr;
  logic              full;
  logic              accept;

  stq_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .base(base), .rd_upd(rd_upd),
    .irq_mask(irq_mask), .ovf_clr(ovf_clr)
  );

  stq_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .advance(accept), .rd_upd(rd_upd),
    .wptr(wptr), .full(full)
  );

  stq_emit #(
    .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W), .PTR_W(PTR_W),
    .ENTRY_WORDS(ENTRY_WORDS)
  ) u_emit (
    .clk(clk), .rst_n(rst_n), .fire(accept), .payload(in_status),
    .base(base), .wptr(wptr), .irq_mask(irq_mask),
    .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
    .irq(irq)
  );

  assign in_ready = !full;
  assign accept   = in_valid && in_ready;

  // A refused offer sets the flag; a fresh set wins over a host clear.
  always_ff @(posedge clk) begin
    if (!rst_n)                overflow <= 1'b0;
    else if (in_valid && full) overflow <= 1'b1;
    else if (ovf_clr)          overflow <= 1'b0;
  end
endmodule

// File: rtl/stq_producer_chk.sv
module stq_producer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        mem_wr_en,
  input logic [31:0] mem_wr_data,
  input logic        irq,
  input logic        overflow,
  input logic        accept,
  input logic        irq_mask,
  input logic        ovf_clr
);
  a_r1_valid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_wr_data[31]);

  a_r2_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_wr_en);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !mem_wr_en);

  a_r4_full_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !mem_wr_en);

  a_r5_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow);

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow);

  a_r6_irq_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mem_wr_en);

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(irq_mask));
endmodule

bind stq_producer stq_producer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .irq(irq),
  .overflow(overflow), .accept(accept), .irq_mask(irq_mask),
  .ovf_clr(ovf_clr)
);

// File: tb/tb_stq_producer.sv
module tb_stq_producer;
  localparam int DEPTH = 16;
  localparam int EW    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [30:0] in_status = '0;
  logic        mem_wr_en;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        irq;
  logic        overflow;

  int checks = 0;
  int fails = 0;
  int writes_seen = 0;
  int irqs_seen = 0;
  int m_wptr = 0;
  logic [31:0] m_base = '0;
  logic [63:0] sb[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  stq_producer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_status(in_status), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [30:0] p);
    logic [31:0] a;
    a = m_base + 32'((m_wptr % DEPTH) * EW);
    sb.push_back({a, 1'b1, p});
    m_wptr = (m_wptr + 1) % DEPTH;
  endtask

  task automatic send(input logic [30:0] p);
    in_valid  = 1'b1;
    in_status = p;
    while (!in_ready) @(negedge clk);
    push_exp(p);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic hreg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      logic [63:0] e;
      writes_seen++;
      if (sb.size() == 0) begin
        chk(0, "R2 unexpected write", {32'h0, mem_wr_addr}, 0);
      end else begin
        e = sb.pop_front();
        chk(mem_wr_addr == e[63:32], "R2/R3 address", mem_wr_addr, e[63:32]);
        chk(mem_wr_data == e[31:0], "R1 entry data", mem_wr_data, e[31:0]);
      end
    end
    if (rst_n && irq) irqs_seen++;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(in_ready == 1'b1, "R8 ready", in_ready, 1);
    chk(mem_wr_en == 1'b0, "R8 wr_en", mem_wr_en, 0);
    chk(irq == 1'b0, "R8 irq", irq, 0);
    chk(overflow == 1'b0, "R8 overflow", overflow, 0);

    // R7 base register, R1 R2 R6 unmasked writes
    hreg(2'd0, 32'h0000_1000); m_base = 32'h0000_1000;
    send(31'h0000_0001);
    send(31'h7fff_ffff);
    send(31'h1234_5678);
    repeat (2) @(negedge clk);
    chk(irqs_seen == 3, "R6 irq per write", irqs_seen, 3);

    // R6 masked
    hreg(2'd2, 32'h1);
    send(31'h0000_00aa);
    send(31'h0000_00bb);
    repeat (2) @(negedge clk);
    chk(irqs_seen == 3, "R6 mask suppresses irq", irqs_seen, 3);
    hreg(2'd2, 32'h0);

    // R7 base change
    hreg(2'd0, 32'h0000_2000); m_base = 32'h0000_2000;
    for (int i = 0; i < 10; i++) send(31'(32'h100 + i));
    @(negedge clk);
    // R4 full with read-update at 0: pointer at 15
    chk(in_ready == 1'b0, "R4 full at DEPTH-1", in_ready, 0);

    // R5 overflow, no write while full
    w0 = writes_seen;
    in_valid = 1'b1; in_status = 31'h0abc_def0;
    repeat (3) @(negedge clk);
    chk(writes_seen == w0, "R4 no write while full", writes_seen, w0);
    chk(overflow == 1'b1, "R5 overflow set", overflow, 1);

    // R9 release held word by moving read-update to 8
    hreg(2'd1, 32'd8);
    chk(in_ready == 1'b1, "R7 read-update frees space", in_ready, 1);
    push_exp(31'h0abc_def0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(writes_seen == w0 + 1, "R9 held word written", writes_seen, w0 + 1);

    // R3 wrap: next entry at base
    send(31'h0000_0777);
    @(negedge clk);
    chk(writes_seen == w0 + 2, "R3 wrapped write", writes_seen, w0 + 2);
    for (int i = 0; i < 6; i++) send(31'(32'h200 + i));
    @(negedge clk);
    chk(in_ready == 1'b0, "R4 full at read-update minus one", in_ready, 0);
    chk(overflow == 1'b1, "R5 overflow sticky", overflow, 1);

    // R5 clear
    hreg(2'd2, 32'h2);
    chk(overflow == 1'b0, "R5 overflow cleared", overflow, 0);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R2 all expected writes seen", sb.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule